// File: doc/BRIEF.md
# Pipelined Symbol Histogram

This block counts how often each symbol value appears in one block of input samples. It is the first pass of an entropy coder. A pulse on `blk_start_i` clears every count bin. The block then takes a fixed number of samples, at most one per clock, and raises `done_o` once the last update has reached memory. Software-free readout follows: the counts are read back by bin address with one cycle of latency.

The counts live in a memory with one read port and one write port. Each sample's bin is read, incremented and written back in a three-step pipeline, so samples are taken without ever stalling. While an update is still in flight, a newer sample can hit the same bin. In that case a forwarding path supplies the pending value in place of the stale memory word, and the youngest pending update wins.

Top module: `sym_histogram`

## Requirements
- R1: After reset, `done_o` is 0, and samples presented before the first `blk_start_i` neither start a block nor raise `done_o`.
- R2: A `blk_start_i` pulse captured at a clock edge starts a clear of all 2^SYM_W bins, which takes exactly 2^SYM_W cycles. Samples offered during the clear are ignored, and a sample presented before the next edge after the clear is taken as the first of the block.
- R3: Each accepted sample with `smp_valid_i` high increments the bin addressed by `smp_sym_i` by one. Samples on consecutive cycles are all taken, with no stall.
- R4: Runs in which the same bin repeats on consecutive cycles, or recurs two samples later, still count every sample. The newest in-flight value for that bin is the one forwarded.
- R5: Repeats of one bin separated by one or two idle cycles count every sample.
- R6: Exactly BLOCK_LEN valid samples are accepted per block. Valid samples after that have no effect on any count.
- R7: Counts are CNT_W bits wide (12 by default), so one bin can reach BLOCK_LEN (2048) without wrapping.
- R8: `done_o` rises three clock edges after the edge that captures the last sample, which is one cycle after that sample's write commits. It then stays high until the next `blk_start_i`.
- R9: When the block is idle or done, `rd_count_o` shows the count of the bin whose address `rd_addr_i` held at the previous clock edge.
- R10: A new `blk_start_i` drops `done_o` at the following edge, and the new block's counts exclude every earlier block's samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_start_i | input | 1 | Start a block: clear the bins, then accept samples |
| smp_valid_i | input | 1 | Sample strobe |
| smp_sym_i | input | SYM_W | Sample symbol value (bin address) |
| rd_addr_i | input | SYM_W | Readout bin address |
| rd_count_o | output | CNT_W | Registered count of the addressed bin |
| done_o | output | 1 | All updates of the block are committed |

## Verification
The bench builds the block with its default values: 8-bit symbols, 12-bit counts and 2048 samples per block. With these values one bin can be driven to its full 2048 count, and every one of the 256 bins is read back after each block. Stimulus covers a constant symbol, a ramp, alternation between two bins, paired repeats, a scrambled sequence, and gaps of one and two idle cycles. Together these place a matching update in each forwarding stage, in neither stage, and in both stages at once.

// File: rtl/hist_pkg.sv
package hist_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_ACCEPT,
    ST_DRAIN,
    ST_DONE
  } hist_state_t;
endpackage

// File: rtl/hist_ram.sv
module hist_ram #(
  parameter int AW = 8,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // read-first: a read and a write to one address on the same edge return the old word
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/hist_fwd.sv
module hist_fwd #(
  parameter int AW = 8,
  parameter int DW = 12
) (
  input  logic [AW-1:0] cur_addr,
  input  logic [DW-1:0] ram_q,
  input  logic          young_v,
  input  logic [AW-1:0] young_addr,
  input  logic [DW-1:0] young_data,
  input  logic          old_v,
  input  logic [AW-1:0] old_addr,
  input  logic [DW-1:0] old_data,
  output logic [DW-1:0] next_cnt
);
  logic [DW-1:0] base;

  always_comb begin
    if (young_v && young_addr == cur_addr)    base = young_data;
    else if (old_v && old_addr == cur_addr)   base = old_data;
    else                                      base = ram_q;
    next_cnt = base + DW'(1);
  end
endmodule

// File: rtl/hist_ctrl.sv
module hist_ctrl
  import hist_pkg::*;
#(
  parameter int AW        = 8,
  parameter int BLOCK_LEN = 2048
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          smp_valid,
  input  logic          pipe_busy,
  output logic          accept,
  output logic          clearing,
  output logic [AW-1:0] clr_addr,
  output logic          done
);
  localparam int LEN_W = $clog2(BLOCK_LEN + 1);
  localparam logic [LEN_W-1:0] LAST_IDX = LEN_W'(BLOCK_LEN - 1);

  hist_state_t      state;
  logic [LEN_W-1:0] taken;

  assign accept   = (state == ST_ACCEPT) && smp_valid && !start;
  assign clearing = (state == ST_CLEAR);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      taken    <= '0;
      clr_addr <= '0;
      done     <= 1'b0;
    end else if (start) begin
      state    <= ST_CLEAR;
      taken    <= '0;
      clr_addr <= '0;
      done     <= 1'b0;
    end else begin
      case (state)
        ST_CLEAR: begin
          clr_addr <= clr_addr + AW'(1);
          if (&clr_addr) state <= ST_ACCEPT;
        end
        ST_ACCEPT: begin
          if (smp_valid) begin
            taken <= taken + LEN_W'(1);
            if (taken == LAST_IDX) state <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (!pipe_busy) begin
            state <= ST_DONE;
            done  <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sym_histogram.sv
module sym_histogram #(
  parameter int SYM_W     = 8,
  parameter int CNT_W     = 12,
  parameter int BLOCK_LEN = 2048
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             blk_start_i,
  input  logic             smp_valid_i,
  input  logic [SYM_W-1:0] smp_sym_i,
  input  logic [SYM_W-1:0] rd_addr_i,
  output logic [CNT_W-1:0] rd_count_o,
  output logic             done_o
);
  logic             accept, clearing;
  logic [SYM_W-1:0] clr_addr;

  // pipeline: s1 = read returned, s2 = write port, s3 = word written last edge
  logic             s1_v, s2_v, s3_v;
  logic [SYM_W-1:0] s1_addr, s2_addr, s3_addr;
  logic [CNT_W-1:0] s2_data, s3_data, inc_cnt, ram_q;

  logic             ram_we;
  logic [SYM_W-1:0] ram_waddr, ram_raddr;
  logic [CNT_W-1:0] ram_wdata;

  hist_ctrl #(.AW(SYM_W), .BLOCK_LEN(BLOCK_LEN)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (blk_start_i),
    .smp_valid (smp_valid_i),
    .pipe_busy (s1_v | s2_v),
    .accept    (accept),
    .clearing  (clearing),
    .clr_addr  (clr_addr),
    .done      (done_o)
  );

  assign ram_raddr = accept ? smp_sym_i : rd_addr_i;
  assign ram_we    = clearing | s2_v;
  assign ram_waddr = clearing ? clr_addr : s2_addr;
  assign ram_wdata = clearing ? '0 : s2_data;

  hist_ram #(.AW(SYM_W), .DW(CNT_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (ram_raddr),
    .rdata (ram_q)
  );

  hist_fwd #(.AW(SYM_W), .DW(CNT_W)) u_fwd (
    .cur_addr   (s1_addr),
    .ram_q      (ram_q),
    .young_v    (s2_v),
    .young_addr (s2_addr),
    .young_data (s2_data),
    .old_v      (s3_v),
    .old_addr   (s3_addr),
    .old_data   (s3_data),
    .next_cnt   (inc_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst || blk_start_i) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
      s3_v <= 1'b0;
    end else begin
      s1_v <= accept;
      s2_v <= s1_v;
      s3_v <= s2_v;
    end
  end

  always_ff @(posedge clk) begin
    s1_addr <= smp_sym_i;
    s2_addr <= s1_addr;
    s2_data <= inc_cnt;
    s3_addr <= s2_addr;
    s3_data <= s2_data;
  end

  assign rd_count_o = ram_q;
endmodule

// File: rtl/hist_chk.sv
module hist_chk #(
  parameter int AW = 8,
  parameter int DW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          blk_start_i,
  input logic          done_o,
  input logic          clearing,
  input logic          s2_v,
  input logic [AW-1:0] s2_addr,
  input logic [DW-1:0] s2_data,
  input logic          s3_v,
  input logic [AW-1:0] s3_addr,
  input logic [DW-1:0] s3_data
);
  // R4
  fwd_chain_chk: assert property (@(posedge clk) disable iff (rst)
    (s2_v && s3_v && s2_addr == s3_addr) |-> (s2_data == s3_data + DW'(1)));

  // R7
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    s2_v |-> (s2_data != '0));

  // R2
  clear_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    clearing |-> !s2_v);

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !blk_start_i) |=> done_o);

  // R8
  done_empty_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> !$past(s2_v));

  // R10
  start_drop_chk: assert property (@(posedge clk) disable iff (rst)
    blk_start_i |=> !done_o);
endmodule

bind sym_histogram hist_chk #(.AW(SYM_W), .DW(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .blk_start_i (blk_start_i),
  .done_o      (done_o),
  .clearing    (clearing),
  .s2_v        (s2_v),
  .s2_addr     (s2_addr),
  .s2_data     (s2_data),
  .s3_v        (s3_v),
  .s3_addr     (s3_addr),
  .s3_data     (s3_data)
);

// File: tb/tb_sym_histogram.sv
module tb_sym_histogram;
  localparam int SYM_W = 8;
  localparam int CNT_W = 12;
  localparam int BLOCK_LEN = 2048;
  localparam int NBIN = 1 << SYM_W;
  localparam logic [7:0] JUNK = 8'h11;

  // vector: {kind[3:0], sym[7:0], gap[3:0]}
  // kind 0 constant, 1 ramp, 2 alternate p/p+1, 3 scrambled, 4 pairs p,p,p+1,p+1
  localparam int NVEC = 7;
  localparam logic [15:0] VECS [NVEC] = '{
    {4'd0, 8'hA5, 4'd0},
    {4'd1, 8'h00, 4'd0},
    {4'd2, 8'h40, 4'd0},
    {4'd0, 8'h3C, 4'd1},
    {4'd0, 8'hFF, 4'd2},
    {4'd3, 8'h5B, 4'd0},
    {4'd4, 8'h80, 4'd0}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             blk_start_i = 1'b0;
  logic             smp_valid_i = 1'b0;
  logic [SYM_W-1:0] smp_sym_i = '0;
  logic [SYM_W-1:0] rd_addr_i = '0;
  logic [CNT_W-1:0] rd_count_o;
  logic             done_o;

  int n_chk = 0;
  int n_bad = 0;
  int expc [NBIN];

  always #10 clk = ~clk;

  sym_histogram #(.SYM_W(SYM_W), .CNT_W(CNT_W), .BLOCK_LEN(BLOCK_LEN)) dut (
    .clk(clk), .rst(rst), .blk_start_i(blk_start_i), .smp_valid_i(smp_valid_i),
    .smp_sym_i(smp_sym_i), .rd_addr_i(rd_addr_i), .rd_count_o(rd_count_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] gen(input int kind, input logic [7:0] p, input int i);
    case (kind)
      0: return p;
      1: return 8'(i);
      2: return p + 8'(i & 1);
      3: return 8'((i * 37) ^ (i >> 3)) + p;
      default: return p + 8'((i >> 1) & 1);
    endcase
  endfunction

  task automatic start_block();
    @(negedge clk);
    blk_start_i = 1'b1;
    smp_valid_i = 1'b0;
    @(posedge clk);
    @(negedge clk);
    blk_start_i = 1'b0;
    // R2: junk offered for the whole clear must not count
    smp_valid_i = 1'b1;
    smp_sym_i   = JUNK;
    repeat (NBIN - 1) @(posedge clk);
    @(negedge clk);
    smp_valid_i = 1'b0;
    @(posedge clk);
  endtask

  task automatic read_all(input string req);
    for (int a = 0; a < NBIN; a++) begin
      @(negedge clk);
      rd_addr_i = SYM_W'(a);
      @(posedge clk);
      @(negedge clk);
      check(rd_count_o == CNT_W'(expc[a]), req, int'(rd_count_o), expc[a]);
    end
  endtask

  task automatic run_block(input logic [15:0] v);
    int kind = int'(v[15:12]);
    logic [7:0] p = v[11:4];
    int gap = int'(v[3:0]);
    for (int b = 0; b < NBIN; b++) expc[b] = 0;
    start_block();
    for (int i = 0; i < BLOCK_LEN; i++) begin
      @(negedge clk);
      smp_valid_i = 1'b1;
      smp_sym_i   = gen(kind, p, i);
      expc[gen(kind, p, i)]++;
      @(posedge clk);
      if (gap > 0) begin
        @(negedge clk);
        smp_valid_i = 1'b0;
        repeat (gap - 1) @(posedge clk);
        if (i != BLOCK_LEN - 1) @(posedge clk);
        else @(posedge clk);
      end
    end
    // edge A just captured the last sample (or gap edges followed)
    @(negedge clk);
    smp_valid_i = 1'b0;
    if (gap == 0) begin
      @(posedge clk); @(negedge clk);
      check(done_o == 1'b0, "R8 early", int'(done_o), 0);
      @(posedge clk); @(negedge clk);
      check(done_o == 1'b0, "R8 early", int'(done_o), 0);
      @(posedge clk); @(negedge clk);
      check(done_o == 1'b1, "R8 rise", int'(done_o), 1);
    end else begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      check(done_o == 1'b1, "R8 done", int'(done_o), 1);
    end
    // R3 R4 R5 R7 R2 R9: all bins against the model
    read_all("R3/R4/R5/R7 bin");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(done_o == 1'b0, "R1 reset", int'(done_o), 0);
    // R1: samples before any start do nothing
    smp_valid_i = 1'b1;
    smp_sym_i = 8'h22;
    repeat (20) @(posedge clk);
    @(negedge clk);
    smp_valid_i = 1'b0;
    check(done_o == 1'b0, "R1 idle", int'(done_o), 0);

    for (int k = 0; k < NVEC; k++) run_block(VECS[k]);

    // R6: extra samples after the block end change nothing
    @(negedge clk);
    smp_valid_i = 1'b1;
    smp_sym_i = 8'h80;
    repeat (12) @(posedge clk);
    @(negedge clk);
    smp_valid_i = 1'b0;
    rd_addr_i = 8'h80;
    @(posedge clk); @(negedge clk);
    check(rd_count_o == CNT_W'(expc[8'h80]), "R6 extra", int'(rd_count_o), expc[8'h80]);
    check(done_o == 1'b1, "R8 hold", int'(done_o), 1);

    // R10: restart drops done, old counts gone
    @(negedge clk);
    blk_start_i = 1'b1;
    @(posedge clk); @(negedge clk);
    blk_start_i = 1'b0;
    check(done_o == 1'b0, "R10 drop", int'(done_o), 0);
    for (int b = 0; b < NBIN; b++) expc[b] = 0;
    repeat (NBIN) @(posedge clk);
    for (int i = 0; i < BLOCK_LEN; i++) begin
      @(negedge clk);
      smp_valid_i = 1'b1;
      smp_sym_i = 8'h07;
      expc[7]++;
      @(posedge clk);
    end
    @(negedge clk);
    smp_valid_i = 1'b0;
    repeat (4) @(posedge clk);
    read_all("R10 bin");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule